// File: doc/BRIEF.md
# Clock Alignment Lock Detector

This block decides whether a feedback pulse stream tracks a reference pulse stream closely enough to call the loop locked. Both streams are sampled in one fast system clock. A rising edge on either input counts as one edge event, so a level held high for several cycles counts once. Each reference edge produces exactly one comparison result. The result is aligned when the nearest feedback edge lies inside a window around that reference edge. The window is set separately for a feedback edge that comes early and for one that comes late.

A second state machine turns the stream of comparison results into a `locked` flag with hysteresis. The flag rises only after a programmed run of consecutive aligned results. It falls only after a programmed number of misaligned results. The alignment counter stops at a programmable ceiling. Four 16-bit configuration words hold all the settings, and each word can be written and read back.

The comparator has two states. `CMP_IDLE` waits for a reference edge and keeps track of how old the most recent feedback edge is. `CMP_WAIT` follows a reference edge that had no early feedback partner and counts cycles until a feedback edge arrives or the window runs out. Its transitions are: idle to idle when a reference edge resolves at once, idle to wait when no early partner exists, wait to idle on a feedback edge or a timeout, and wait to wait when a new reference edge arrives. The lock machine also has two states. It goes from `LK_UNLOCKED` to `LK_LOCKED` once the required run of aligned results is reached, and from `LK_LOCKED` to `LK_UNLOCKED` once the miss count is reached or on reset.

Top module: `align_lock_detector`

## Requirements
- R1: After a synchronous reset, `locked` is 0 and the configuration words read back as: word 0 = 0x0604, word 1 = 1000, word 2 = 1, word 3 = 1001.
- R2: Word 0 holds the early window in bits [4:0] and the late window in bits [12:8]. Words 1, 2 and 3 hold the lock run length, the miss limit and the counter ceiling in bits [9:0]. Bits outside these fields read as 0 and ignore writes. `cfg_addr` selects the word.
- R3: A feedback edge that comes d cycles after a reference edge, with 0 <= d <= late window, makes that comparison aligned.
- R4: A feedback edge that comes d cycles before a reference edge, with 1 <= d <= early window, makes that comparison aligned.
- R5: A comparison is misaligned when its feedback edge lies outside both windows, or when no feedback edge arrives within the larger window after the reference edge.
- R6: While unlocked, `locked` rises on the aligned comparison that brings the consecutive count to the lock run length, and not on the one before it. With the reset default this is the 1000th comparison.
- R7: A misaligned comparison while unlocked sets the alignment count back to zero.
- R8: While locked, `locked` falls on the misaligned comparison that brings the miss count to the miss limit. An aligned comparison while locked sets the miss count back to zero.
- R9: The alignment count stops at the ceiling. If the ceiling is below the lock run length, `locked` never rises, and the count kept at the ceiling carries over when the ceiling is later raised.
- R10: Asserting `rst` while locked drops `locked`, clears both counters and restores the default configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both pulse streams |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference pulse stream |
| fb_in | input | 1 | Feedback pulse stream |
| cfg_we | input | 1 | Write strobe for the configuration word selected by `cfg_addr` |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Contents of the selected configuration word |
| locked | output | 1 | Lock indication with hysteresis |

## Verification
Assertions check four things on every cycle. The comparator never stays in its wait state beyond the window range. An aligned result only comes from a cycle that had an edge. `locked` only rises right after an aligned result and only falls right after a misaligned result or a reset. A miss while unlocked always empties the alignment count. Some behaviours can only be shown by the bench's scenarios, which count out whole sequences of pulse pairs: the exact count at which the flag changes, the boundary offsets of each window, the miss counter being cleared by an aligned result, the count held at the ceiling, and the restore on reset.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    parameter int WIN_W  = 5;
    parameter int CNT_W  = 10;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 2;

    typedef enum logic {
        CMP_IDLE,
        CMP_WAIT
    } cmp_state_e;

    typedef enum logic {
        LK_UNLOCKED,
        LK_LOCKED
    } lock_state_e;

    typedef struct packed {
        logic [WIN_W-1:0] early_win;
        logic [WIN_W-1:0] late_win;
        logic [CNT_W-1:0] run_len;
        logic [CNT_W-1:0] miss_lim;
        logic [CNT_W-1:0] ceiling;
    } lockdet_cfg_t;

endpackage

// File: rtl/lockdet_cfg_regs.sv
module lockdet_cfg_regs
    import lockdet_pkg::*;
#(
    parameter logic [WIN_W-1:0] EARLY_RST = 5'd4,
    parameter logic [WIN_W-1:0] LATE_RST  = 5'd6,
    parameter logic [CNT_W-1:0] RUN_RST   = 10'd1000,
    parameter logic [CNT_W-1:0] MISS_RST  = 10'd1,
    parameter logic [CNT_W-1:0] CEIL_RST  = 10'd1001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output lockdet_cfg_t      cfg
);

    localparam int NWORDS   = 2 ** ADDR_W;
    localparam int LATE_LSB = 8;
    localparam logic [DATA_W-1:0] WIN_MASK =
        DATA_W'(((1 << WIN_W) - 1) | (((1 << WIN_W) - 1) << LATE_LSB));
    localparam logic [DATA_W-1:0] CNT_MASK = DATA_W'((1 << CNT_W) - 1);

    function automatic logic [DATA_W-1:0] word_rst(input int idx);
        case (idx)
            0:       return DATA_W'(EARLY_RST) | (DATA_W'(LATE_RST) << LATE_LSB);
            1:       return DATA_W'(RUN_RST);
            2:       return DATA_W'(MISS_RST);
            default: return DATA_W'(CEIL_RST);
        endcase
    endfunction

    logic [DATA_W-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        localparam logic [DATA_W-1:0] MASK = (g == 0) ? WIN_MASK : CNT_MASK;
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= word_rst(g);
            end else if (we && (addr == ADDR_W'(g))) begin
                words[g] <= wdata & MASK;
            end
        end
    end

    assign rdata = words[addr];

    assign cfg.early_win = words[0][WIN_W-1:0];
    assign cfg.late_win  = words[0][LATE_LSB +: WIN_W];
    assign cfg.run_len   = words[1][CNT_W-1:0];
    assign cfg.miss_lim  = words[2][CNT_W-1:0];
    assign cfg.ceiling   = words[3][CNT_W-1:0];

endmodule

// File: rtl/lockdet_phase_cmp.sv
module lockdet_phase_cmp
    import lockdet_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [WIN_W-1:0] early_win,
    input  logic [WIN_W-1:0] late_win,
    output logic             res_valid,
    output logic             res_aligned
);

    localparam int AGE_W = WIN_W + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    cmp_state_e       st, st_n;
    logic             ref_q, fb_q;
    logic             ref_edge, fb_edge;
    logic [AGE_W-1:0] wcnt, wcnt_n;
    logic [AGE_W-1:0] fb_age;
    logic             fb_seen;
    logic [AGE_W-1:0] early_x, late_x, wide_x;
    logic             hit, ok, consume;

    assign ref_edge = ref_in & ~ref_q;
    assign fb_edge  = fb_in & ~fb_q;
    assign early_x  = {1'b0, early_win};
    assign late_x   = {1'b0, late_win};
    assign wide_x   = (early_x > late_x) ? early_x : late_x;

    // Next-state and result decision
    always_comb begin
        st_n    = st;
        wcnt_n  = wcnt;
        hit     = 1'b0;
        ok      = 1'b0;
        consume = 1'b0;
        unique case (st)
            CMP_IDLE: begin
                if (ref_edge) begin
                    if (fb_edge) begin
                        hit     = 1'b1;
                        ok      = 1'b1;
                        consume = 1'b1;
                    end else if (fb_seen && (fb_age <= early_x)) begin
                        hit     = 1'b1;
                        ok      = 1'b1;
                        consume = 1'b1;
                    end else begin
                        st_n    = CMP_WAIT;
                        wcnt_n  = AGE_W'(1);
                        consume = 1'b1;
                    end
                end
            end
            CMP_WAIT: begin
                wcnt_n = wcnt + AGE_W'(1);
                if (fb_edge) begin
                    hit     = 1'b1;
                    ok      = (wcnt <= late_x);
                    consume = 1'b1;
                    st_n    = CMP_IDLE;
                end else if (wcnt >= wide_x) begin
                    hit  = 1'b1;
                    st_n = CMP_IDLE;
                end
                if (ref_edge) begin
                    if (!hit) begin
                        hit = 1'b1;
                    end
                    st_n   = CMP_WAIT;
                    wcnt_n = AGE_W'(1);
                end
            end
            default: st_n = CMP_IDLE;
        endcase
    end

    // State and tracking registers
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= CMP_IDLE;
            wcnt    <= '0;
            ref_q   <= 1'b0;
            fb_q    <= 1'b0;
            fb_seen <= 1'b0;
            fb_age  <= AGE_MAX;
        end else begin
            st    <= st_n;
            wcnt  <= wcnt_n;
            ref_q <= ref_in;
            fb_q  <= fb_in;
            if (fb_edge && !consume) begin
                fb_seen <= 1'b1;
                fb_age  <= AGE_W'(1);
            end else begin
                if (consume) begin
                    fb_seen <= 1'b0;
                end
                if (fb_age != AGE_MAX) begin
                    fb_age <= fb_age + AGE_W'(1);
                end
            end
        end
    end

    // Result outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_aligned <= 1'b0;
        end else begin
            res_valid   <= hit;
            res_aligned <= hit & ok;
        end
    end

    // R5
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st == CMP_WAIT) |-> (wcnt <= AGE_W'(1 << WIN_W)));

    // R3
    align_src_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_aligned) |-> $past(ref_edge || fb_edge));

endmodule

// File: rtl/lockdet_lock_fsm.sv
module lockdet_lock_fsm
    import lockdet_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic             res_aligned,
    input  logic [CNT_W-1:0] run_len,
    input  logic [CNT_W-1:0] miss_lim,
    input  logic [CNT_W-1:0] ceiling,
    output logic             locked
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    lock_state_e      st, st_n;
    logic [CNT_W-1:0] align_cnt, align_cnt_n, align_inc;
    logic [CNT_W-1:0] miss_cnt, miss_cnt_n, miss_inc;

    assign align_inc = (align_cnt >= ceiling) ? ceiling : align_cnt + CNT_W'(1);
    assign miss_inc  = (miss_cnt == CNT_MAX) ? CNT_MAX : miss_cnt + CNT_W'(1);

    always_comb begin
        st_n        = st;
        align_cnt_n = align_cnt;
        miss_cnt_n  = miss_cnt;
        unique case (st)
            LK_UNLOCKED: begin
                if (res_valid) begin
                    if (res_aligned) begin
                        align_cnt_n = align_inc;
                        if (align_inc >= run_len) begin
                            st_n       = LK_LOCKED;
                            miss_cnt_n = '0;
                        end
                    end else begin
                        align_cnt_n = '0;
                    end
                end
            end
            LK_LOCKED: begin
                if (res_valid) begin
                    if (res_aligned) begin
                        miss_cnt_n  = '0;
                        align_cnt_n = align_inc;
                    end else begin
                        miss_cnt_n = miss_inc;
                        if (miss_inc >= miss_lim) begin
                            st_n        = LK_UNLOCKED;
                            align_cnt_n = '0;
                            miss_cnt_n  = '0;
                        end
                    end
                end
            end
            default: st_n = LK_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LK_UNLOCKED;
            align_cnt <= '0;
            miss_cnt  <= '0;
        end else begin
            st        <= st_n;
            align_cnt <= align_cnt_n;
            miss_cnt  <= miss_cnt_n;
        end
    end

    assign locked = (st == LK_LOCKED);

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(res_valid && res_aligned));

    // R8
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && !$past(rst)) |-> $past(res_valid && !res_aligned));

    // R7
    align_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && res_valid && !res_aligned) |=> (align_cnt == '0));

endmodule

// File: rtl/align_lock_detector.sv
module align_lock_detector
    import lockdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              fb_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              locked
);

    lockdet_cfg_t cfg;
    logic         res_valid;
    logic         res_aligned;

    lockdet_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    lockdet_phase_cmp u_cmp (
        .clk         (clk),
        .rst         (rst),
        .ref_in      (ref_in),
        .fb_in       (fb_in),
        .early_win   (cfg.early_win),
        .late_win    (cfg.late_win),
        .res_valid   (res_valid),
        .res_aligned (res_aligned)
    );

    lockdet_lock_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .res_valid   (res_valid),
        .res_aligned (res_aligned),
        .run_len     (cfg.run_len),
        .miss_lim    (cfg.miss_lim),
        .ceiling     (cfg.ceiling),
        .locked      (locked)
    );

endmodule

// File: tb/align_lock_detector_tb.sv
module align_lock_detector_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0;
    logic        fb_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        locked;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_rd;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];

    localparam int GAP = 36;

    always #4 clk = ~clk;

    align_lock_detector u_dut (
        .clk       (clk),
        .rst       (rst),
        .ref_in    (ref_in),
        .fb_in     (fb_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .locked    (locked)
    );

    // Monitor: pops expected items and compares them to the outputs
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sbq.size() > 0) begin
                sb_item_t it;
                logic [15:0] act;
                it = sbq.pop_front();
                act = it.is_rd ? cfg_rdata : {15'd0, locked};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_lock(input bit exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.is_rd = 1'b0;
        it.exp = {15'd0, exp};
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic push_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        cfg_addr = a;
        it.is_rd = 1'b1;
        it.exp = exp;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // delta > 0: feedback after reference; delta < 0: feedback before
    task automatic pair(input int delta, input bit has_fb);
        int a = (delta < 0) ? -delta : 0;
        int b = a + delta;
        int span = a + ((delta < 0) ? 0 : delta) + 1 + GAP;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            ref_in = (i == a);
            fb_in = has_fb && (i == b);
        end
        ref_in = 1'b0;
        fb_in = 1'b0;
    endtask

    task automatic pairs(input int n, input int delta, input bit has_fb);
        for (int k = 0; k < n; k++) pair(delta, has_fb);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        push_lock(1'b0, "R1 locked after reset");
        push_rd(2'd0, 16'h0604, "R1 window word default");
        push_rd(2'd1, 16'd1000, "R1 run length default");
        push_rd(2'd2, 16'd1, "R1 miss limit default");
        push_rd(2'd3, 16'd1001, "R1 ceiling default");

        // R6: default run length 1000
        pairs(999, 0, 1'b1);
        push_lock(1'b0, "R6 not locked after 999 aligned");
        pair(0, 1'b1);
        push_lock(1'b1, "R6 locked on 1000th aligned");

        // R8 + R5: default miss limit 1, missing feedback
        pair(0, 1'b0);
        push_lock(1'b0, "R8 single miss unlocks / R5 missing feedback");

        // R2: register map
        wr(2'd0, 16'hFFFF);
        push_rd(2'd0, 16'h1F1F, "R2 unused window bits ignored");
        wr(2'd1, 16'hFC04);
        push_rd(2'd1, 16'h0004, "R2 run length field");
        wr(2'd0, 16'h0302);
        push_rd(2'd0, 16'h0302, "R2 window readback");
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd1023);
        push_rd(2'd3, 16'd1023, "R2 ceiling readback");

        // R3: late feedback at the late window edge
        pairs(3, 3, 1'b1);
        push_lock(1'b0, "R3 not locked after 3 late-edge pairs");
        pair(3, 1'b1);
        push_lock(1'b1, "R3 locked after 4 late-edge pairs");

        // R8: miss counting and clearing
        pairs(2, 4, 1'b1);
        push_lock(1'b1, "R8 still locked after 2 misses");
        pair(0, 1'b1);
        pairs(2, 4, 1'b1);
        push_lock(1'b1, "R8 aligned pair cleared miss count");
        pair(4, 1'b1);
        push_lock(1'b0, "R8 unlocked on third consecutive miss");

        // R4: early feedback at the early window edge
        pairs(3, -2, 1'b1);
        push_lock(1'b0, "R4 not locked after 3 early pairs");
        pair(-2, 1'b1);
        push_lock(1'b1, "R4 locked after 4 early pairs");

        // R5: early feedback beyond the window
        pairs(3, -3, 1'b1);
        push_lock(1'b0, "R5 too-early feedback is a miss");

        // R7: miss while unlocked restarts the run
        pairs(3, 0, 1'b1);
        pair(-3, 1'b1);
        pairs(3, 0, 1'b1);
        push_lock(1'b0, "R7 run restarted after miss");
        pair(0, 1'b1);
        push_lock(1'b1, "R7 locked on fourth after restart");
        pairs(3, 0, 1'b0);
        push_lock(1'b0, "R5 unlocked by missing feedback");

        // R9: ceiling below run length
        wr(2'd3, 16'd2);
        push_rd(2'd3, 16'd2, "R9 ceiling written");
        pairs(6, 0, 1'b1);
        push_lock(1'b0, "R9 never locks with ceiling below run");
        wr(2'd3, 16'd1023);
        pair(0, 1'b1);
        push_lock(1'b0, "R9 count held at ceiling (3 of 4)");
        pair(0, 1'b1);
        push_lock(1'b1, "R9 locked after ceiling raised");

        // R10: reset while locked
        pairs(2, 0, 1'b1);
        do_reset();
        push_lock(1'b0, "R10 reset drops locked");
        push_rd(2'd1, 16'd1000, "R10 run length restored");
        wr(2'd1, 16'd4);
        pairs(3, 0, 1'b1);
        push_lock(1'b0, "R10 counters cleared by reset");
        pair(0, 1'b1);
        push_lock(1'b1, "R10 locks after full run");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule